// File: doc/BRIEF.md
# PLL Lock Qualification Controller

This block decides whether a frequency-tuned PLL has really locked. On a start request it programs a frequency window word for the PLL: an upper limit, a lower limit and a tuning-enable flag. It then samples the PLL's lock status once per sample interval. A lock is accepted only after the status bit has been seen and has then stayed set for a long run of further consecutive samples.

An attempt fails if lock never appears within a bounded number of samples, or if the status drops during the qualification run. After a failed attempt the window is kept but tuning is switched off, and another attempt begins. The number of attempts is bounded. When a lock qualifies, the tuning flag is cleared and the limits stay in place. The outcome is shown on two sticky flags, pass and fail, which hold until the next start request.

All counts are parameters: the sample interval in system clocks, the poll limit, the hold run length, the attempt count and the tolerance added to the low limit. A testbench can therefore shrink the long default windows.

Top module: `pll_lock_qual`

## Requirements
- R1: After reset, `cfg_word` is all zero and `tune_en`, `lock_pass` and `lock_fail` are 0.
- R2: The clock edge that sees `start` high loads `cfg_word` with the following fields. Bits 31:16 hold `win_lo + TOL` as a 16-bit zero-extended sum (TOL defaults to 2). Bit 8 is 1. Bits LO_W-1:0 hold `win_lo`. All other bits are 0. `tune_en` always equals bit 8.
- R3: `lock_in` is sampled once every SAMPLE_CLKS clocks. The first sample falls on the edge SAMPLE_CLKS clocks after the start edge. Neither flag rises before the sample that ends the run.
- R4: An attempt fails when POLL_LIMIT consecutive samples in the polling phase all see `lock_in` low.
- R5: A sample that sees `lock_in` high in the polling phase opens a hold run. If the next HOLD_LIMIT samples all see it high, `lock_pass` rises at the edge of the last of them. A low sample during the run fails the attempt.
- R6: On a qualified lock, bit 8 of `cfg_word` is cleared and the two limit fields keep their loaded values.
- R7: A failed attempt clears bit 8 and starts a new attempt with a fresh poll count. The failure of attempt number MAX_TRIES raises `lock_fail`.
- R8: `lock_pass` and `lock_fail` are never high together. Each stays high, whatever `lock_in` does, until the next `start`.
- R9: `start` restarts the whole sequence from any state, including during a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin (or restart) a qualification sequence |
| lock_in | input | 1 | PLL lock status bit |
| win_lo | input | LO_W | Low frequency limit captured at start |
| cfg_word | output | 32 | Programmed window word for the PLL |
| tune_en | output | 1 | Tuning-enable flag (bit 8 of cfg_word) |
| lock_pass | output | 1 | Sticky: lock qualified |
| lock_fail | output | 1 | Sticky: all attempts exhausted |

## Verification
Lock status is driven as one or two high windows, placed by sample index relative to the start edge. Each pattern separates a different outcome:
- Lock from the first sample gives the shortest pass.
- Lock that never comes exhausts every attempt.
- A drop on the last sample of a hold run tells an off-by-one in the hold count from a correct one.
- Lock first seen on the final poll sample, or one sample later, pins the poll limit.
- Lock appearing only in the last attempt, or just past it, pins the attempt bound.

Every sample is checked for the flags and the tuning bit, so both an early verdict and a late one show up. Directed cases cover:
- a restart in mid-run;
- a window value whose upper limit carries out of the low field;
- lock activity after a verdict, which must leave the flags unchanged.

// File: rtl/pllq_pkg.sv
// Package: shared state type and window-word layout for the PLL lock
// qualifier. Assumes a 32-bit window word whose fields are fixed by the PLL.
package pllq_pkg;
    localparam int WORD_W   = 32;
    localparam int HI_LSB   = 16;
    localparam int HI_W     = 16;
    localparam int TUNE_BIT = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_HOLD,
        ST_PASS,
        ST_FAIL
    } pllq_state_e;
endpackage

// File: rtl/pllq_sample_timer.sv
// Sample timer: raises a one-clock tick every SAMPLE_CLKS clocks while run is
// high. Assumes clear coincides with the start of a sequence so the first
// tick lands SAMPLE_CLKS clocks after it.
module pllq_sample_timer #(
    parameter int SAMPLE_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int CW = (SAMPLE_CLKS > 1) ? $clog2(SAMPLE_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SAMPLE_CLKS - 1);

    logic [CW-1:0] cnt;

    // Count clocks within the current sample interval.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (run)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // Tick on the last clock of each interval.
    always_comb tick = run && !clear && (cnt == LAST);
endmodule

// File: rtl/pllq_window_reg.sv
// Window register: forms and holds the PLL window word. The upper limit is
// the low limit plus TOL, the tuning flag is set on load and cleared on
// request. Assumes LO_W <= TUNE_BIT so the low field never overlaps the flag.
module pllq_window_reg
    import pllq_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int TOL  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                tune_clr,
    input  logic [LO_W-1:0]     win_lo,
    output logic [WORD_W-1:0]   word
);
    logic [WORD_W-1:0] load_val;
    logic [HI_W-1:0]   hi_lim;

    // Build the word to load from the low limit.
    always_comb begin
        hi_lim   = HI_W'(win_lo) + HI_W'(TOL);
        load_val = '0;
        load_val[HI_LSB +: HI_W] = hi_lim;
        load_val[TUNE_BIT]       = 1'b1;
        load_val[LO_W-1:0]       = win_lo;
    end

    // Hold the word; only the tuning flag changes between loads.
    always_ff @(posedge clk) begin
        if (!rst_n)         word <= '0;
        else if (load)      word <= load_val;
        else if (tune_clr)  word[TUNE_BIT] <= 1'b0;
    end
endmodule

// File: rtl/pllq_attempt_fsm.sv
// Attempt sequencer: polls the lock bit on each tick, qualifies it over a
// hold run, retries failed attempts and records the sticky verdict. Assumes
// POLL_LIMIT, HOLD_LIMIT and MAX_TRIES are all at least 1.
module pllq_attempt_fsm
    import pllq_pkg::*;
#(
    parameter int POLL_LIMIT = 20480,
    parameter int HOLD_LIMIT = 4096,
    parameter int MAX_TRIES  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    input  logic lock_in,
    output logic busy,
    output logic tune_clr,
    output logic pass,
    output logic fail
);
    localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
    localparam int HW = (HOLD_LIMIT > 1) ? $clog2(HOLD_LIMIT) : 1;
    localparam int TW = (MAX_TRIES  > 1) ? $clog2(MAX_TRIES)  : 1;
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_LIMIT - 1);
    localparam logic [TW-1:0] TRY_LAST  = TW'(MAX_TRIES - 1);

    pllq_state_e     state;
    logic [PW-1:0]   poll_cnt;
    logic [HW-1:0]   hold_cnt;
    logic [TW-1:0]   try_cnt;
    logic            att_fail;
    logic            qualified;

    // Decode the end of an attempt on this sample.
    always_comb begin
        att_fail  = tick && !lock_in &&
                    ((state == ST_POLL && poll_cnt == POLL_LAST) ||
                     (state == ST_HOLD));
        qualified = tick && lock_in && state == ST_HOLD && hold_cnt == HOLD_LAST;
    end

    // Advance state and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            poll_cnt <= '0;
            hold_cnt <= '0;
            try_cnt  <= '0;
        end else if (start) begin
            state    <= ST_POLL;
            poll_cnt <= '0;
            hold_cnt <= '0;
            try_cnt  <= '0;
        end else if (att_fail) begin
            if (try_cnt == TRY_LAST) begin
                state <= ST_FAIL;
            end else begin
                try_cnt  <= try_cnt + 1'b1;
                poll_cnt <= '0;
                state    <= ST_POLL;
            end
        end else if (qualified) begin
            state <= ST_PASS;
        end else if (tick) begin
            if (state == ST_POLL) begin
                if (lock_in) begin
                    state    <= ST_HOLD;
                    hold_cnt <= '0;
                end else begin
                    poll_cnt <= poll_cnt + 1'b1;
                end
            end else if (state == ST_HOLD) begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    // Derive status outputs from the state.
    always_comb begin
        busy     = (state == ST_POLL) || (state == ST_HOLD);
        pass     = (state == ST_PASS);
        fail     = (state == ST_FAIL);
        tune_clr = !start && (att_fail || qualified);
    end
endmodule

// File: rtl/pll_lock_qual.sv
// Top: PLL lock qualifier. Loads the window word on start, samples lock on
// a parameterised timer, qualifies it over a hold run with bounded retries.
// Assumes start is a synchronous request; lock_in is already synchronised.
module pll_lock_qual
    import pllq_pkg::*;
#(
    parameter int LO_W        = 8,
    parameter int TOL         = 2,
    parameter int SAMPLE_CLKS = 4,
    parameter int POLL_LIMIT  = 20480,
    parameter int HOLD_LIMIT  = 4096,
    parameter int MAX_TRIES   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            lock_in,
    input  logic [LO_W-1:0] win_lo,
    output logic [31:0]     cfg_word,
    output logic            tune_en,
    output logic            lock_pass,
    output logic            lock_fail
);
    logic tick;
    logic busy;
    logic tune_clr;

    pllq_sample_timer #(.SAMPLE_CLKS(SAMPLE_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .run   (busy),
        .tick  (tick)
    );

    pllq_attempt_fsm #(
        .POLL_LIMIT (POLL_LIMIT),
        .HOLD_LIMIT (HOLD_LIMIT),
        .MAX_TRIES  (MAX_TRIES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (tick),
        .lock_in  (lock_in),
        .busy     (busy),
        .tune_clr (tune_clr),
        .pass     (lock_pass),
        .fail     (lock_fail)
    );

    pllq_window_reg #(.LO_W(LO_W), .TOL(TOL)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .tune_clr (tune_clr),
        .win_lo   (win_lo),
        .word     (cfg_word)
    );

    // Expose the tuning flag as its own pin.
    always_comb tune_en = cfg_word[TUNE_BIT];
endmodule

// File: rtl/pllq_checker.sv
// Checker: temporal properties of the PLL lock qualifier, bound to the top.
module pllq_checker #(
    parameter int LO_W = 8,
    parameter int TOL  = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [LO_W-1:0] win_lo,
    input logic [31:0]     cfg_word,
    input logic            tune_en,
    input logic            lock_pass,
    input logic            lock_fail
);
    a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> tune_en && cfg_word[31:16] == (16'($past(win_lo)) + 16'(TOL))
                  && cfg_word[LO_W-1:0] == $past(win_lo));

    a_r6_limits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(cfg_word[31:16]) && $stable(cfg_word[LO_W-1:0]));

    a_r7_tune_only_rises_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !$rose(tune_en));

    a_r6_tune_off_at_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_pass || lock_fail) |-> !tune_en);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lock_pass && lock_fail));

    a_r8_pass_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_pass && !start |=> lock_pass);

    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_fail && !start |=> lock_fail);

    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !lock_pass && !lock_fail);
endmodule

bind pll_lock_qual pllq_checker #(.LO_W(LO_W), .TOL(TOL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .win_lo    (win_lo),
    .cfg_word  (cfg_word),
    .tune_en   (tune_en),
    .lock_pass (lock_pass),
    .lock_fail (lock_fail)
);

// File: tb/pll_lock_qual_tb.sv
`timescale 1ns/1ps
// Bench: vector table of lock windows with hand-computed verdicts, followed
// by directed reset, sticky, restart and ignore cases.
module pll_lock_qual_tb;
    localparam int N   = 3;
    localparam int P   = 10;
    localparam int H   = 6;
    localparam int T   = 4;
    localparam int NEV = 1000;
    localparam int NV  = 10;

    // lock high for samples [ON1,OFF1) and from ON2; verdict at sample S;
    // first failed attempt at sample F (0 = none); PS = 1 for pass.
    localparam int V_ON1  [NV] = '{1,   5,   NEV, 3,   2,  10,  11,  31,  41,  4};
    localparam int V_OFF1 [NV] = '{NEV, NEV, NEV, 6,   8,  NEV, NEV, NEV, NEV, 5};
    localparam int V_ON2  [NV] = '{NEV, NEV, NEV, NEV, 9,  NEV, NEV, NEV, NEV, 12};
    localparam int V_S    [NV] = '{7,   11,  40,  36,  15, 16,  17,  37,  40,  18};
    localparam int V_F    [NV] = '{0,   0,   10,  6,   8,  0,   10,  10,  10,  5};
    localparam int V_PS   [NV] = '{1,   1,   0,   0,   1,  1,   1,   1,   0,   1};
    localparam int V_LO   [NV] = '{8'h30, 8'h00, 8'hFE, 8'h12, 8'hFF, 8'h21, 8'h7F, 8'h80, 8'h01, 8'h55};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        lock_in = 1'b0;
    logic [7:0]  win_lo = '0;
    logic [31:0] cfg_word;
    logic        tune_en;
    logic        lock_pass;
    logic        lock_fail;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pll_lock_qual #(
        .LO_W(8), .TOL(2), .SAMPLE_CLKS(N),
        .POLL_LIMIT(P), .HOLD_LIMIT(H), .MAX_TRIES(T)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .lock_in(lock_in),
        .win_lo(win_lo), .cfg_word(cfg_word), .tune_en(tune_en),
        .lock_pass(lock_pass), .lock_fail(lock_fail)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int lo, input logic tune);
        logic [31:0] w;
        w = '0;
        w[31:16] = 16'(lo) + 16'd2;
        w[8]     = tune;
        w[7:0]   = 8'(lo);
        return w;
    endfunction

    // Pulse start at the current negedge; returns at the negedge after the start edge.
    task automatic pulse_start(input int lo);
        start  = 1'b1;
        win_lo = 8'(lo);
        @(posedge clk);
        @(negedge clk);
        start  = 1'b0;
    endtask

    // Run one table vector; called at a negedge.
    task automatic run_vec(input int i);
        logic lk;
        logic tn;
        logic dn;
        lock_in = 1'b0;
        pulse_start(V_LO[i]);
        check("R2 load word", cfg_word, exp_word(V_LO[i], 1'b1));
        check("R2 tune pin", {31'd0, tune_en}, 32'd1);
        for (int j = 1; j <= V_S[i]; j++) begin
            lk = ((j >= V_ON1[i]) && (j < V_OFF1[i])) || (j >= V_ON2[i]);
            lock_in = lk;
            repeat (N) @(posedge clk);
            @(negedge clk);
            dn = (j == V_S[i]);
            tn = !dn && ((V_F[i] == 0) || (j < V_F[i]));
            if (!dn)
                check("R3 R4 R7 mid-run flags/tune", {29'd0, lock_pass, lock_fail, tune_en},
                      {29'd0, 1'b0, 1'b0, tn});
            else if (V_PS[i] == 1)
                check("R5 verdict pass", {29'd0, lock_pass, lock_fail, tune_en}, {29'd0, 3'b100});
            else
                check("R7 verdict fail", {29'd0, lock_pass, lock_fail, tune_en}, {29'd0, 3'b010});
        end
        check("R6 limits kept, tune off", cfg_word, exp_word(V_LO[i], 1'b0));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset word", cfg_word, 32'd0);
        check("R1 reset flags", {29'd0, tune_en, lock_pass, lock_fail}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {29'd0, tune_en, lock_pass, lock_fail}, 32'd0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            run_vec(i);
            if (i == 0) begin
                // R8: pass holds while lock toggles.
                for (int k = 0; k < 20; k++) begin
                    lock_in = k[0];
                    @(negedge clk);
                end
                check("R8 pass sticky", {30'd0, lock_pass, lock_fail}, 32'd2);
                check("R8 word untouched", cfg_word, exp_word(V_LO[0], 1'b0));
            end
            if (i == 2) begin
                // R8: lock after fail verdict has no effect.
                lock_in = 1'b1;
                repeat (30) @(negedge clk);
                check("R8 fail sticky with lock high", {30'd0, lock_pass, lock_fail}, 32'd1);
                lock_in = 1'b0;
            end
        end

        // R9: restart in mid-run, then a clean pass from the new start.
        lock_in = 1'b0;
        pulse_start(8'h44);
        repeat (5 * N) @(negedge clk);
        check("R9 still running", {30'd0, lock_pass, lock_fail}, 32'd0);
        run_vec(0);

        // R9: restart during a hold run discards the partial run.
        pulse_start(8'h10);
        lock_in = 1'b1;
        repeat (3 * N) @(negedge clk);
        run_vec(1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule